// File: doc/BRIEF.md
# UART Receiver with Status FIFO

This block turns an asynchronous serial line into a stream of characters. It runs from a clock-enable pulse at sixteen times the bit rate. A falling edge on the idle-high line opens a start-bit check. If the start bit holds, the block shifts in a character of 5 to 8 data bits, least significant bit first. It then checks an optional parity bit and one or two stop bits. It also recognises a line held low for a whole frame as a break.

Each finished character goes into a 16-entry FIFO. Four error flags travel with the character in the same entry, so software reading the stream knows exactly which character was damaged. The read side is a valid/ready stream. `out_valid` stays high while the FIFO holds an entry. An entry is removed on every clock edge where `out_valid` and `out_ready` are both high. While `out_ready` is low, the head entry and its flags are held unchanged. The receiver never waits for the reader. When the reader falls behind and the FIFO is full, new characters are lost and the loss is recorded.

The frame format comes from plain configuration inputs, which a line-control register outside this block holds steady. They should only change while the line is idle.

Top module: `uart_rx_core`

## Requirements
- R1: While reset is asserted and right after it is released, `out_valid` is low and the FIFO is empty.
- R2: A low level that no longer reads low at the 8th oversampling tick after the falling edge is discarded as a glitch and produces no entry.
- R3: Data bits are sampled every 16 ticks after the start-bit check and assembled LSB first. `cfg_len` values 0, 1, 2 and 3 select 5, 6, 7 and 8 bits. Unused upper bits of `out_data` read zero.
- R4: With `cfg_par_en` high, one parity bit follows the data. `cfg_par_even` high expects even parity over data plus parity bit, and low expects odd parity. A mismatch sets `out_status[1]`.
- R5: `cfg_stop2` selects two stop bits instead of one. If any stop bit samples low, `out_status[0]` (framing) is set.
- R6: A frame whose start, data, parity and stop samples are all low is stored as a single entry with data 0x00 and `out_status` = 4'b0101 (break and framing, parity clear). No new start is detected until the line has been seen high.
- R7: The FIFO holds 16 entries and delivers them in arrival order.
- R8: A character completing while the FIFO is full is dropped, and `out_status[3]` (overrun) is set on the newest stored entry.
- R9: While `out_valid` is high and `out_ready` is low, `out_data` and `out_status` hold steady. One entry is removed per cycle with both high.
- R10: A character with correct parity and stop bits has `out_status` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Clock enable at 16x the bit rate |
| rxd | input | 1 | Serial input, idle high, synchronised inside |
| cfg_len | input | 2 | Data bits minus 5 |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | 1 = even parity, 0 = odd |
| cfg_stop2 | input | 1 | 1 = two stop bits |
| out_valid | output | 1 | FIFO head is valid |
| out_ready | input | 1 | Consumer accepts the head entry |
| out_data | output | 8 | Received character |
| out_status | output | 4 | {overrun, break, parity error, framing error} |

## Verification
Parity checking and stop-bit checking finish in the same push, and so do break and framing detection. The bench provokes the first case with a frame that carries both a wrong parity bit and a low stop bit, and expects both flags in one entry. It provokes the second with an all-low frame that has parity enabled, where the break rule must clear the parity flag while keeping framing. A third case pairs a completing character with a full FIFO under a stalled reader. The scoreboard then expects the drop and the overrun mark on the sixteenth entry, followed by in-order delivery once the reader resumes.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef struct packed {
    logic ovr;  // bit 3
    logic brk;  // bit 2
    logic par;  // bit 1
    logic frm;  // bit 0
  } rx_stat_t;

  localparam int STAT_W = 4;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_state_e;
endpackage

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler
  import uart_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       line,
  input  logic [1:0] cfg_len,
  input  logic       cfg_par_en,
  input  logic       cfg_par_even,
  input  logic       cfg_stop2,
  output logic       push,
  output logic [7:0] push_data,
  output rx_stat_t   push_stat
);
  localparam int CNT_W = $clog2(OSR);
  localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OSR / 2 - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(OSR - 1);

  rx_state_e        state;
  logic [CNT_W-1:0] cnt;
  logic [2:0]       bit_idx;
  logic [7:0]       shreg;
  logic             par_acc, par_bad, frm_bad, all_low, stop_idx, prev;

  logic       last_bit, sample_frm, sample_low;
  logic [2:0] last_idx;

  assign last_idx   = {1'b0, cfg_len} + 3'd4;
  assign last_bit   = (bit_idx == last_idx);
  assign sample_frm = frm_bad | ~line;
  assign sample_low = all_low & ~line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= RX_IDLE;
      cnt       <= '0;
      bit_idx   <= '0;
      shreg     <= '0;
      par_acc   <= 1'b0;
      par_bad   <= 1'b0;
      frm_bad   <= 1'b0;
      all_low   <= 1'b0;
      stop_idx  <= 1'b0;
      prev      <= 1'b1;
      push      <= 1'b0;
      push_data <= '0;
      push_stat <= '0;
    end else begin
      push <= 1'b0;
      if (tick) begin
        case (state)
          RX_IDLE: begin
            prev <= line;
            if (prev && !line) begin
              state <= RX_START;
              cnt   <= '0;
            end
          end
          RX_START: begin
            if (cnt == MID_CNT) begin
              cnt <= '0;
              if (line) begin
                state <= RX_IDLE;
                prev  <= 1'b1;
              end else begin
                state   <= RX_DATA;
                bit_idx <= '0;
                shreg   <= '0;
                par_acc <= 1'b0;
                par_bad <= 1'b0;
                frm_bad <= 1'b0;
                all_low <= 1'b1;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_DATA: begin
            if (cnt == FULL_CNT) begin
              cnt            <= '0;
              shreg[bit_idx] <= line;
              par_acc        <= par_acc ^ line;
              if (line) all_low <= 1'b0;
              if (last_bit) begin
                state    <= cfg_par_en ? RX_PAR : RX_STOP;
                stop_idx <= 1'b0;
              end else begin
                bit_idx <= bit_idx + 1'b1;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_PAR: begin
            if (cnt == FULL_CNT) begin
              cnt     <= '0;
              par_bad <= par_acc ^ line ^ ~cfg_par_even;
              if (line) all_low <= 1'b0;
              state   <= RX_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_STOP: begin
            if (cnt == FULL_CNT) begin
              cnt <= '0;
              if (cfg_stop2 && !stop_idx) begin
                stop_idx <= 1'b1;
                frm_bad  <= sample_frm;
                all_low  <= sample_low;
              end else begin
                push          <= 1'b1;
                push_data     <= sample_low ? 8'h00 : shreg;
                push_stat.ovr <= 1'b0;
                push_stat.brk <= sample_low;
                push_stat.par <= sample_low ? 1'b0 : par_bad;
                push_stat.frm <= sample_frm;
                state         <= RX_IDLE;
                prev          <= line;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  parameter int SW    = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [W-1:0]               wr_data,
  input  logic [SW-1:0]              wr_stat,
  input  logic                       rd_en,
  output logic [W-1:0]               rd_data,
  output logic [SW-1:0]              rd_stat,
  output logic                       empty,
  output logic                       full,
  output logic [$clog2(DEPTH):0]     level
);
  localparam int AW = $clog2(DEPTH);
  localparam int EW = W + SW;

  logic [EW-1:0] mem [DEPTH];
  logic [AW:0]   wr_ptr, rd_ptr;
  logic [AW-1:0] newest;
  logic          wr_ok, rd_ok;

  assign level  = wr_ptr - rd_ptr;
  assign full   = (level == (AW + 1)'(DEPTH));
  assign empty  = (level == '0);
  assign wr_ok  = wr_en && !full;
  assign rd_ok  = rd_en && !empty;
  assign newest = wr_ptr[AW-1:0] - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (wr_ok) wr_ptr <= wr_ptr + 1'b1;
      if (rd_ok) rd_ptr <= rd_ptr + 1'b1;
    end
  end

  // the overrun flag is the top bit of each entry
  always_ff @(posedge clk) begin
    if (wr_ok) begin
      mem[wr_ptr[AW-1:0]] <= {wr_stat, wr_data};
    end else if (wr_en && full) begin
      mem[newest][EW-1] <= 1'b1;
    end
  end

  assign rd_data = mem[rd_ptr[AW-1:0]][W-1:0];
  assign rd_stat = mem[rd_ptr[AW-1:0]][EW-1:W];
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       rxd,
  input  logic [1:0] cfg_len,
  input  logic       cfg_par_en,
  input  logic       cfg_par_even,
  input  logic       cfg_stop2,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic [3:0] out_status
);
  localparam int LVL_W = $clog2(DEPTH) + 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   line;
  logic                   fe_push;
  logic [7:0]             fe_data;
  rx_stat_t               fe_stat;
  logic                   fifo_empty, fifo_full;
  logic [LVL_W-1:0]       fifo_level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
  end
  assign line = sync_q[SYNC_STAGES-1];

  uart_rx_sampler #(.OSR(OSR)) sampler_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tick16),
    .line         (line),
    .cfg_len      (cfg_len),
    .cfg_par_en   (cfg_par_en),
    .cfg_par_even (cfg_par_even),
    .cfg_stop2    (cfg_stop2),
    .push         (fe_push),
    .push_data    (fe_data),
    .push_stat    (fe_stat)
  );

  uart_rx_fifo #(.DEPTH(DEPTH), .W(8), .SW(STAT_W)) fifo_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (fe_push),
    .wr_data (fe_data),
    .wr_stat (fe_stat),
    .rd_en   (out_ready),
    .rd_data (out_data),
    .rd_stat (out_status),
    .empty   (fifo_empty),
    .full    (fifo_full),
    .level   (fifo_level)
  );

  assign out_valid = !fifo_empty;
endmodule

// File: rtl/uart_rx_core_chk.sv
module uart_rx_core_chk #(
  parameter int DEPTH = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic [7:0]              out_data,
  input logic [3:0]              out_status,
  input logic                    push,
  input logic [7:0]              push_data,
  input logic [3:0]              push_stat,
  input logic                    full,
  input logic [$clog2(DEPTH):0]  level
);
  logic pop;
  assign pop = out_valid && out_ready;

  AST_EMPTY_IN_RESET: assert property (@(posedge clk) !rst_n |-> !out_valid); // R1

  AST_BREAK_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    push && push_stat[2] |-> (push_data == 8'h00) && push_stat[0] && !push_stat[1]); // R6

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    level <= ($clog2(DEPTH) + 1)'(DEPTH)); // R7

  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    push && !full && !pop |=> level == $past(level) + 1'b1); // R7

  AST_DROP_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    push && full && !pop |=> level == $past(level)); // R8

  AST_HOLD_WHEN_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_status)); // R9
endmodule

bind uart_rx_core uart_rx_core_chk #(.DEPTH(DEPTH)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_data   (out_data),
  .out_status (out_status),
  .push       (fe_push),
  .push_data  (fe_data),
  .push_stat  (fe_stat),
  .full       (fifo_full),
  .level      (fifo_level)
);

// File: tb/uart_rx_core_tb.sv
module uart_rx_core_tb_top;
  localparam int TICK_DIV = 4;
  localparam int BIT_CLKS = 16 * TICK_DIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic       rxd = 1'b1;
  logic [1:0] cfg_len = 2'd3;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_even = 1'b0;
  logic       cfg_stop2 = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [7:0] out_data;
  logic [3:0] out_status;

  int checks = 0;
  int fails = 0;
  logic [11:0] exp_q[$];
  string       tag_q[$];
  int          tick_cnt = 0;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    tick_cnt <= (tick_cnt == TICK_DIV - 1) ? 0 : tick_cnt + 1;
    tick16   <= (tick_cnt == TICK_DIV - 1);
  end

  uart_rx_core dut_i (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
    .cfg_stop2(cfg_stop2), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_status(out_status)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic line_bit(input logic v);
    rxd = v;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  task automatic set_ready(input logic v);
    @(posedge clk);
    #2 out_ready = v;
  endtask

  // bad_stop: 0 none, 1 first stop low, 2 second stop low
  task automatic send_frame(input logic [7:0] d, input int nb, input bit pe, input bit ev,
                            input bit st2, input bit bad_par, input int bad_stop,
                            input bit expect_it, input string tag);
    logic [7:0] dm;
    logic       pbit;
    logic [3:0] st;
    dm = d & 8'((1 << nb) - 1);
    pbit = ev ? ^dm : ~^dm;
    if (bad_par) pbit = ~pbit;
    cfg_len = 2'(nb - 5);
    cfg_par_en = pe;
    cfg_par_even = ev;
    cfg_stop2 = st2;
    st = {2'b00, pe & bad_par, bad_stop != 0};
    if (expect_it) begin
      exp_q.push_back({st, dm});
      tag_q.push_back(tag);
    end
    line_bit(1'b0);
    for (int i = 0; i < nb; i++) line_bit(dm[i]);
    if (pe) line_bit(pbit);
    line_bit(bad_stop == 1 ? 1'b0 : 1'b1);
    if (st2) line_bit(bad_stop == 2 ? 1'b0 : 1'b1);
    line_bit(1'b1);
  endtask

  task automatic wait_drain;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // monitor: compares each handshake against the scoreboard
  initial begin
    logic [11:0] e;
    string t;
    forever begin
      @(negedge clk);
      if (rst_n && out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2/R7 unexpected entry", {20'h0, out_status, out_data}, 32'h0);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk({out_status, out_data} == e, t, {20'h0, out_status, out_data}, {20'h0, e});
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 32'h0, 32'h1);
    finish_run();
  end

  initial begin
    logic [7:0] held_d;
    logic [3:0] held_s;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 valid in reset", {31'h0, out_valid}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(out_valid == 1'b0, "R1 valid after reset", {31'h0, out_valid}, 32'h0);
    line_bit(1'b1);
    set_ready(1'b1);

    // R3 / R10: lengths, LSB first, clean status
    send_frame(8'hA5, 8, 0, 0, 0, 0, 0, 1, "R3 R10 8-bit");
    send_frame(8'hFF, 5, 0, 0, 0, 0, 0, 1, "R3 5-bit upper zero");
    send_frame(8'h2D, 6, 0, 0, 0, 0, 0, 1, "R3 6-bit");
    send_frame(8'h4E, 7, 0, 0, 0, 0, 0, 1, "R3 7-bit");

    // R4 parity
    send_frame(8'h37, 8, 1, 1, 0, 0, 0, 1, "R4 even good");
    send_frame(8'h37, 8, 1, 0, 0, 0, 0, 1, "R4 odd good");
    send_frame(8'h5A, 8, 1, 1, 0, 1, 0, 1, "R4 even bad");
    send_frame(8'h11, 6, 1, 0, 0, 1, 0, 1, "R4 odd bad");

    // R5 stop bits
    send_frame(8'hC3, 8, 0, 0, 1, 0, 0, 1, "R5 two stop good");
    send_frame(8'h3C, 8, 0, 0, 1, 0, 2, 1, "R5 second stop low");
    send_frame(8'h66, 8, 0, 0, 0, 0, 1, 1, "R5 single stop low");
    // R4 and R5 together in one entry
    send_frame(8'h81, 8, 1, 1, 0, 1, 1, 1, "R4 R5 parity and framing");
    wait_drain();

    // R2 glitch: low for 4 ticks only
    rxd = 1'b0;
    repeat (4 * TICK_DIV) @(negedge clk);
    line_bit(1'b1);
    line_bit(1'b1);
    send_frame(8'h3C, 8, 0, 0, 0, 0, 0, 1, "R2 char after glitch");
    wait_drain();

    // R6 break with odd parity enabled, line held low past the frame
    cfg_len = 2'd3; cfg_par_en = 1'b1; cfg_par_even = 1'b0; cfg_stop2 = 1'b0;
    exp_q.push_back({4'b0101, 8'h00});
    tag_q.push_back("R6 break entry");
    repeat (14) line_bit(1'b0);
    line_bit(1'b1);
    send_frame(8'h81, 8, 0, 0, 0, 0, 0, 1, "R6 char after break");
    wait_drain();

    // R9 back-pressure
    set_ready(1'b0);
    send_frame(8'h12, 8, 0, 0, 0, 0, 0, 1, "R9 stalled first");
    send_frame(8'h34, 8, 0, 0, 0, 0, 0, 1, "R9 stalled second");
    @(negedge clk);
    chk(out_valid == 1'b1, "R9 valid while stalled", {31'h0, out_valid}, 32'h1);
    held_d = out_data;
    held_s = out_status;
    repeat (20) @(negedge clk);
    chk(out_data == 8'h12 && held_d == 8'h12, "R9 head held", {24'h0, out_data}, 32'h12);
    chk(out_status == held_s, "R9 status held", {28'h0, out_status}, {28'h0, held_s});
    set_ready(1'b1);
    wait_drain();

    // R7 / R8: fill 16, then one more while full
    set_ready(1'b0);
    for (int i = 0; i < 17; i++)
      send_frame(8'(i * 7 + 1), 8, 0, 0, 0, 0, 0, i < 16, "R7 order");
    exp_q[exp_q.size() - 1] = exp_q[exp_q.size() - 1] | 12'h800;
    tag_q[tag_q.size() - 1] = "R8 overrun on newest";
    chk(out_valid == 1'b1, "R7 full holds data", {31'h0, out_valid}, 32'h1);
    set_ready(1'b1);
    wait_drain();
    chk(out_valid == 1'b0, "R8 dropped char absent", {31'h0, out_valid}, 32'h0);
    finish_run();
  end
endmodule